// File: doc/BRIEF.md
# Trap Entry and Return Context Switch Unit

This block carries out the three processor instructions that move between a running program and a trap handler while saving and restoring processor state. It watches the decoded instruction stream. When it accepts a system call or a software interrupt, it copies the current instruction pointer, stack pointer and flag word into three shadow registers. It then reads a handler address from an external vector table and hands the core a new instruction pointer and a flag word with two bits cleared. The stack pointer is left alone on entry.

On a trap return it hands back all three saved values in one cycle. The software interrupt and the trap return are privileged: in user mode they raise a one-cycle fault and change nothing. Each next-state output comes with a one-cycle load strobe. The core writes a value into its own register only while that strobe is high. The vector table and the fetch logic sit outside the block.

Top module: `ctxsw_unit`

## Requirements
- R1: After synchronous reset, every strobe output, `busy_o` and `fault_o` are 0, and all three shadow registers are zero. A trap return issued straight after reset therefore loads 0 into the IP, SP and flag outputs.
- R2: An accepted system call (opcode 162) is legal in either mode. The edge that accepts it sets `vec_req_o` high for exactly one cycle with `vec_idx_o` = 6 and sets `busy_o` high.
- R3: An accepted software interrupt (opcode 192) in privileged mode (`user_mode_i` = 0) behaves the same way, except that `vec_idx_o` equals `imm_i`, including the extremes 0 and 255.
- R4: The table word arrives on `vec_data_i` one cycle after the request. Two clock edges after acceptance, `ip_load_o` pulses for one cycle with `nxt_ip_o` equal to that word, and `busy_o` falls on the same edge.
- R5: On that same entry edge, `flg_load_o` pulses with `nxt_flg_o` equal to the flag word sampled at acceptance with bits 16 and 17 forced to 0. `sp_load_o` stays 0 throughout entry.
- R6: Entry stores IP, SP and the flag word as sampled on the accepting edge into shadow slots 0, 1 and 2. The slots hold these values until the next accepted entry.
- R7: An accepted trap return (opcode 193) in privileged mode makes `ip_load_o`, `sp_load_o` and `flg_load_o` pulse together on the next edge for one cycle. The outputs carry shadow slots 0, 1 and 2. There is no table request and no busy period.
- R8: A software interrupt or trap return issued with `user_mode_i` = 1 pulses `fault_o` for one cycle. It raises no load strobe and no table request, and it leaves the shadow registers unchanged.
- R9: While `busy_o` is 1, every instruction is ignored. It causes no fault, no new request and no shadow update.
- R10: Any other opcode, and any cycle with `op_valid_i` = 0, produces no output activity and leaves the shadow registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Decoded instruction present this cycle |
| opcode_i | input | 8 | Decoded opcode |
| imm_i | input | IMM_W | Immediate field; vector number for a software interrupt |
| user_mode_i | input | 1 | 1 = user level, 0 = privileged |
| cur_ip_i | input | DATA_W | Current instruction pointer |
| cur_sp_i | input | DATA_W | Current stack pointer |
| cur_flg_i | input | DATA_W | Current flag word |
| vec_data_i | input | DATA_W | Vector table read data, one cycle after the request |
| vec_idx_o | output | IMM_W | Vector table read index |
| vec_req_o | output | 1 | Vector table read strobe |
| nxt_ip_o | output | DATA_W | Next instruction pointer |
| ip_load_o | output | 1 | Load strobe for `nxt_ip_o` |
| nxt_sp_o | output | DATA_W | Next stack pointer |
| sp_load_o | output | 1 | Load strobe for `nxt_sp_o` |
| nxt_flg_o | output | DATA_W | Next flag word |
| flg_load_o | output | 1 | Load strobe for `nxt_flg_o` |
| busy_o | output | 1 | Entry sequence in progress |
| fault_o | output | 1 | Privilege fault pulse |

## Verification
The bench starts with a trap return straight after reset. A design that did not clear its shadow registers would hand back stale or unknown values there. It sets every bit of the flag word on entry, which exposes a clear mask that misses bit 16 or 17 or touches a neighbour. It also drives vector numbers 0, 255 and 42, which catch an index that is truncated or taken from the fixed system vector.

Instructions issued during the busy window, including a user-mode interrupt, expose a unit that restarts, faults or overwrites its saved context. The later return shows whether that happened. User-mode faults are followed by a privileged return, which shows whether a faulting instruction leaked into the shadow registers. Every event is matched against the cycle it is due in, so a load that comes one cycle early or late is reported.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_SYSCALL = 8'd162;
  localparam logic [OPC_W-1:0] OPC_SWINT   = 8'd192;
  localparam logic [OPC_W-1:0] OPC_TRETURN = 8'd193;

  localparam int NUM_SLOTS = 3;
  localparam int SLOT_IP   = 0;
  localparam int SLOT_SP   = 1;
  localparam int SLOT_FLG  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_LOAD = 2'd2
  } seq_st_t;

endpackage

// File: rtl/ctxsw_decode.sv
module ctxsw_decode
  import ctxsw_pkg::*;
(
  input  logic             op_valid_i,
  input  logic             busy_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             user_mode_i,
  output logic             enter_sys_o,
  output logic             enter_int_o,
  output logic             do_return_o,
  output logic             priv_fault_o
);

  logic live;
  logic is_sys, is_int, is_ret;
  logic needs_priv;

  always_comb begin
    live       = op_valid_i && !busy_i;
    is_sys     = (opcode_i == OPC_SYSCALL);
    is_int     = (opcode_i == OPC_SWINT);
    is_ret     = (opcode_i == OPC_TRETURN);
    needs_priv = is_int || is_ret;

    enter_sys_o  = live && is_sys;
    enter_int_o  = live && is_int && !user_mode_i;
    do_return_o  = live && is_ret && !user_mode_i;
    priv_fault_o = live && needs_priv && user_mode_i;
  end

endmodule

// File: rtl/ctxsw_shadow.sv
module ctxsw_shadow
  import ctxsw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cap_en_i,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  cap_data_i,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  shadow_o
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_o[s] <= '0;
      end else if (cap_en_i) begin
        shadow_o[s] <= cap_data_i[s];
      end
    end
  end

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en_i |=> $stable(shadow_o));

  // R6
  shadow_take_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en_i |=> (shadow_o == $past(cap_data_i)));

endmodule

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
  import ctxsw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 8,
  parameter int SYS_VEC = 6,
  parameter int CLR_A   = 16,
  parameter int CLR_B   = 17
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             enter_sys_i,
  input  logic                             enter_int_i,
  input  logic                             do_return_i,
  input  logic                             fault_req_i,
  input  logic [IMM_W-1:0]                 imm_i,
  input  logic [DATA_W-1:0]                vec_data_i,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] shadow_i,
  output logic [IMM_W-1:0]                 vec_idx_o,
  output logic                             vec_req_o,
  output logic [DATA_W-1:0]                nxt_ip_o,
  output logic                             ip_load_o,
  output logic [DATA_W-1:0]                nxt_sp_o,
  output logic                             sp_load_o,
  output logic [DATA_W-1:0]                nxt_flg_o,
  output logic                             flg_load_o,
  output logic                             busy_o,
  output logic                             fault_o
);

  localparam logic [IMM_W-1:0]  SYS_IDX  = IMM_W'(SYS_VEC);
  localparam logic [DATA_W-1:0] CLR_MASK =
    ~((DATA_W'(1) << CLR_A) | (DATA_W'(1) << CLR_B));

  seq_st_t state;
  logic    entering;

  always_comb entering = enter_sys_i || enter_int_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      vec_idx_o  <= '0;
      vec_req_o  <= 1'b0;
      nxt_ip_o   <= '0;
      nxt_sp_o   <= '0;
      nxt_flg_o  <= '0;
      ip_load_o  <= 1'b0;
      sp_load_o  <= 1'b0;
      flg_load_o <= 1'b0;
      busy_o     <= 1'b0;
      fault_o    <= 1'b0;
    end else begin
      vec_req_o  <= 1'b0;
      ip_load_o  <= 1'b0;
      sp_load_o  <= 1'b0;
      flg_load_o <= 1'b0;
      fault_o    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (entering) begin
            vec_idx_o <= enter_sys_i ? SYS_IDX : imm_i;
            vec_req_o <= 1'b1;
            busy_o    <= 1'b1;
            state     <= ST_REQ;
          end else if (do_return_i) begin
            nxt_ip_o   <= shadow_i[SLOT_IP];
            nxt_sp_o   <= shadow_i[SLOT_SP];
            nxt_flg_o  <= shadow_i[SLOT_FLG];
            ip_load_o  <= 1'b1;
            sp_load_o  <= 1'b1;
            flg_load_o <= 1'b1;
          end else if (fault_req_i) begin
            fault_o <= 1'b1;
          end
        end
        ST_REQ: begin
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          nxt_ip_o   <= vec_data_i;
          nxt_flg_o  <= shadow_i[SLOT_FLG] & CLR_MASK;
          ip_load_o  <= 1'b1;
          flg_load_o <= 1'b1;
          busy_o     <= 1'b0;
          state      <= ST_IDLE;
        end
        default: begin
          busy_o <= 1'b0;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  // R2
  vec_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |=> (!vec_req_o && busy_o));

  // R4
  entry_load_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> ##2 (ip_load_o && !busy_o));

  // R5
  entry_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ip_load_o && !sp_load_o) |-> (flg_load_o && !nxt_flg_o[CLR_A] && !nxt_flg_o[CLR_B]));

  // R7
  return_load_chk: assert property (@(posedge clk) disable iff (rst)
    sp_load_o |-> (ip_load_o && flg_load_o && !busy_o && !vec_req_o));

  // R8
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!ip_load_o && !vec_req_o && !busy_o));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> vec_req_o);

endmodule

// File: rtl/ctxsw_unit.sv
module ctxsw_unit
  import ctxsw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 8,
  parameter int SYS_VEC = 6,
  parameter int CLR_A   = 16,
  parameter int CLR_B   = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              user_mode_i,
  input  logic [DATA_W-1:0] cur_ip_i,
  input  logic [DATA_W-1:0] cur_sp_i,
  input  logic [DATA_W-1:0] cur_flg_i,
  input  logic [DATA_W-1:0] vec_data_i,
  output logic [IMM_W-1:0]  vec_idx_o,
  output logic              vec_req_o,
  output logic [DATA_W-1:0] nxt_ip_o,
  output logic              ip_load_o,
  output logic [DATA_W-1:0] nxt_sp_o,
  output logic              sp_load_o,
  output logic [DATA_W-1:0] nxt_flg_o,
  output logic              flg_load_o,
  output logic              busy_o,
  output logic              fault_o
);

  logic enter_sys, enter_int, do_return, priv_fault;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] cap_data;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] shadow;

  always_comb begin
    cap_data[SLOT_IP]  = cur_ip_i;
    cap_data[SLOT_SP]  = cur_sp_i;
    cap_data[SLOT_FLG] = cur_flg_i;
  end

  ctxsw_decode u_decode (
    .op_valid_i   (op_valid_i),
    .busy_i       (busy_o),
    .opcode_i     (opcode_i),
    .user_mode_i  (user_mode_i),
    .enter_sys_o  (enter_sys),
    .enter_int_o  (enter_int),
    .do_return_o  (do_return),
    .priv_fault_o (priv_fault)
  );

  ctxsw_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .cap_en_i   (enter_sys || enter_int),
    .cap_data_i (cap_data),
    .shadow_o   (shadow)
  );

  ctxsw_seq #(
    .DATA_W  (DATA_W),
    .IMM_W   (IMM_W),
    .SYS_VEC (SYS_VEC),
    .CLR_A   (CLR_A),
    .CLR_B   (CLR_B)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .enter_sys_i (enter_sys),
    .enter_int_i (enter_int),
    .do_return_i (do_return),
    .fault_req_i (priv_fault),
    .imm_i       (imm_i),
    .vec_data_i  (vec_data_i),
    .shadow_i    (shadow),
    .vec_idx_o   (vec_idx_o),
    .vec_req_o   (vec_req_o),
    .nxt_ip_o    (nxt_ip_o),
    .ip_load_o   (ip_load_o),
    .nxt_sp_o    (nxt_sp_o),
    .sp_load_o   (sp_load_o),
    .nxt_flg_o   (nxt_flg_o),
    .flg_load_o  (flg_load_o),
    .busy_o      (busy_o),
    .fault_o     (fault_o)
  );

  // R9
  busy_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && op_valid_i) |=> !fault_o);

  // R8
  user_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && op_valid_i && user_mode_i && (opcode_i == OPC_SWINT))
      |=> (fault_o && !vec_req_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !op_valid_i) |=> (!vec_req_o && !sp_load_o && !fault_o));

endmodule

// File: tb/test_ctxsw_unit.sv
`timescale 1ns/1ps
module test_ctxsw_unit;

  localparam int DW = 32;
  localparam int IW = 8;
  localparam logic [DW-1:0] MASK = 32'hFFFC_FFFF;

  localparam int K_VREQ  = 0;
  localparam int K_ENTRY = 1;
  localparam int K_RET   = 2;
  localparam int K_FAULT = 3;

  typedef struct {
    int          kind;
    int          cyc;
    logic [31:0] a, b, c;
    string       req;
  } item_t;

  logic clk = 0, rst = 1;
  logic op_valid_i = 0, user_mode_i = 0;
  logic [7:0] opcode_i = 0;
  logic [IW-1:0] imm_i = 0;
  logic [DW-1:0] cur_ip_i = 0, cur_sp_i = 0, cur_flg_i = 0, vec_data_i = 0;
  logic [IW-1:0] vec_idx_o;
  logic vec_req_o, ip_load_o, sp_load_o, flg_load_o, busy_o, fault_o;
  logic [DW-1:0] nxt_ip_o, nxt_sp_o, nxt_flg_o;

  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  item_t q[$];
  logic [DW-1:0] m_ip = 0, m_sp = 0, m_flg = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] tbl(input logic [IW-1:0] i);
    return 32'h4000_0000 | (32'(i) << 4);
  endfunction

  always @(posedge clk) if (vec_req_o) vec_data_i <= tbl(vec_idx_o);

  ctxsw_unit i_ctxsw_unit (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .opcode_i(opcode_i),
    .imm_i(imm_i), .user_mode_i(user_mode_i), .cur_ip_i(cur_ip_i),
    .cur_sp_i(cur_sp_i), .cur_flg_i(cur_flg_i), .vec_data_i(vec_data_i),
    .vec_idx_o(vec_idx_o), .vec_req_o(vec_req_o), .nxt_ip_o(nxt_ip_o),
    .ip_load_o(ip_load_o), .nxt_sp_o(nxt_sp_o), .sp_load_o(sp_load_o),
    .nxt_flg_o(nxt_flg_o), .flg_load_o(flg_load_o), .busy_o(busy_o),
    .fault_o(fault_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int c, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] cc, input string req);
    item_t it;
    it.kind = kind; it.cyc = c; it.a = a; it.b = b; it.c = cc; it.req = req;
    q.push_back(it);
  endtask

  task automatic take(input int kind, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] c);
    item_t e;
    if (q.size() == 0) begin
      chk(0, "R10", "unexpected event kind", 32'(kind), 32'hFFFF_FFFF);
      return;
    end
    e = q.pop_front();
    chk(e.kind == kind, e.req, "event kind", 32'(kind), 32'(e.kind));
    chk(e.cyc == cyc, e.req, "event cycle", 32'(cyc), 32'(e.cyc));
    chk(e.a == a && e.b == b && e.c == c, e.req, "field a", a, e.a);
    if (e.b != b) $display("FAIL %s field b: actual %h expected %h", e.req, b, e.b);
    if (e.c != c) $display("FAIL %s field c: actual %h expected %h", e.req, c, e.c);
  endtask

  // Monitor: pops expected items as the outputs produce events.
  always @(negedge clk) begin
    if (!rst) begin
      if (vec_req_o) take(K_VREQ, 32'(vec_idx_o), 32'(busy_o), 0);
      if (ip_load_o && !sp_load_o) take(K_ENTRY, nxt_ip_o, nxt_flg_o, {31'd0, flg_load_o});
      if (sp_load_o) take(K_RET, nxt_ip_o, nxt_sp_o, nxt_flg_o);
      if (fault_o) take(K_FAULT, 0, 0, 0);
      if (!ip_load_o && flg_load_o) chk(0, "R5", "flag load without ip load", 1, 0);
    end
  end

  // Drives one instruction for one accepting edge; entered and left at a negedge.
  task automatic issue(input logic [7:0] op, input logic [IW-1:0] imm, input bit um,
                       input logic [DW-1:0] ip, input logic [DW-1:0] sp,
                       input logic [DW-1:0] flg);
    op_valid_i = 1; opcode_i = op; imm_i = imm; user_mode_i = um;
    cur_ip_i = ip; cur_sp_i = sp; cur_flg_i = flg;
    @(posedge clk);
    @(negedge clk);
    op_valid_i = 0;
  endtask

  task automatic entry(input logic [7:0] op, input logic [IW-1:0] imm, input bit um,
                       input logic [DW-1:0] ip, input logic [DW-1:0] sp,
                       input logic [DW-1:0] flg, input string req);
    int acc = cyc + 1;
    logic [IW-1:0] idx = (op == 8'd162) ? IW'(6) : imm;
    push(K_VREQ, acc, 32'(idx), 1, 0, req);
    push(K_ENTRY, acc + 2, tbl(idx), flg & MASK, 1, req);
    m_ip = ip; m_sp = sp; m_flg = flg;
    issue(op, imm, um, ip, sp, flg);
  endtask

  task automatic tret(input string req);
    push(K_RET, cyc + 1, m_ip, m_sp, m_flg, req);
    issue(8'd193, 0, 0, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state of outputs
    chk(!busy_o && !fault_o && !vec_req_o && !ip_load_o && !sp_load_o && !flg_load_o,
        "R1", "outputs after reset",
        {26'd0, busy_o, fault_o, vec_req_o, ip_load_o, sp_load_o, flg_load_o}, 0);
    idle(2);
    // R1 R7 return right after reset gives zero context
    tret("R1");
    idle(2);
    // R2 R4 R5 R11 system call from user mode, all flag bits set
    entry(8'd162, 8'h99, 1, 32'hA000_0010, 32'h0000_8000, 32'hFFFF_FFFF, "R2");
    idle(4);
    // R6 R7 return restores captured context
    tret("R6");
    idle(2);
    // R3 software interrupt vector 42
    entry(8'd192, 8'd42, 0, 32'h0000_0ABC, 32'h0000_7FF0, 32'h0003_0005, "R3");
    idle(4);
    // R8 user-mode interrupt and return fault, no state change
    push(K_FAULT, cyc + 1, 0, 0, 0, "R8");
    issue(8'd192, 8'd7, 1, 32'h5, 32'h6, 32'h7);
    push(K_FAULT, cyc + 1, 0, 0, 0, "R8");
    issue(8'd193, 8'd0, 1, 32'h5, 32'h6, 32'h7);
    idle(2);
    tret("R8");
    idle(2);
    // R9 instructions during busy are ignored
    entry(8'd162, 8'h00, 0, 32'hC0DE_0000, 32'h0000_1234, 32'h0002_0000, "R9");
    issue(8'd192, 8'd3, 0, 32'hDEAD_0001, 32'hDEAD_0002, 32'hDEAD_0003);
    issue(8'd192, 8'd3, 1, 32'hDEAD_0001, 32'hDEAD_0002, 32'hDEAD_0003);
    idle(3);
    tret("R9");
    idle(2);
    // R10 no valid strobe, and an unrelated opcode
    cur_ip_i = 32'hBAD0_0000;
    opcode_i = 8'd162; op_valid_i = 0; idle(2);
    issue(8'd1, 8'd0, 0, 32'hBAD1, 32'hBAD2, 32'hBAD3);
    issue(8'd161, 8'd0, 0, 32'hBAD1, 32'hBAD2, 32'hBAD3);
    idle(2);
    tret("R10");
    idle(2);
    // R3 vector extremes
    entry(8'd192, 8'd255, 0, 32'h0000_00F0, 32'h0000_00F4, 32'h0001_0000, "R3");
    idle(3);
    entry(8'd192, 8'd0, 0, 32'h0000_0100, 32'h0000_0104, 32'h8000_0001, "R3");
    idle(3);
    tret("R6");
    idle(6);
    chk(q.size() == 0, "R4", "events still pending", 32'(q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule